// File: doc/BRIEF.md
# Memory Bit-Field Engine

This block carries out one bit-field operation on byte-addressed memory per request. A request gives a base byte address, a signed bit offset, a length code, an operation code and, for insertion, a value. The engine works out which bytes hold the field, fetches them one at a time over a byte-wide memory port, and computes the result together with the negative and zero condition flags. Operations that change the field then store every fetched byte back.

The field may begin below the base address, since the offset can be negative. It may also span up to five bytes, because a field of up to 32 bits can start at any bit of its first byte. Bits are numbered from the most significant bit of the lowest-addressed byte. The engine serves an instruction sequencer that holds `start` for one cycle and waits for `done`.

Top module: `bfu_mem_bitfield`

## Requirements
- R1: A length code of 0 selects a 32-bit field. Any other code n (1..31) selects an n-bit field.
- R2: The first byte accessed is base + floor(offset / 8), using arithmetic division, so a negative offset reaches below the base. The field starts at bit position offset mod 8 within that byte.
- R3: The engine issues exactly floor((bitpos + len - 1) / 8) + 1 reads (1 to 5), one per byte, at ascending addresses. Read data is taken from `mem_rdata` in the cycle after the read request.
- R4: Field bit 0 is bit 7 (the MSB) of the first byte. Later field bits run toward bit 0 of that byte and then continue into the next byte.
- R5: Op code 0 returns the field zero-extended to 32 bits. Op code 1 returns it sign-extended. Op code 7 behaves exactly like op code 0.
- R6: Op code 2 replaces the field with the low len bits of `ins_val`. The result is those bits, zero-extended.
- R7: Op code 3 inverts the field, op code 4 clears it and op code 5 sets it to all ones. For each of these the result is the old field value, zero-extended.
- R8: Op codes 2 to 5 write back every byte that was read, in ascending address order, and only after all reads are complete. Bits outside the field keep their values. Op codes 0, 1, 6 and 7 issue no writes.
- R9: Op code 6 returns the offset plus the number of leading zeros in the field. When the field is all zeros it returns the offset plus the length.
- R10: `flag_n` is the MSB of the flag value and `flag_z` is set when the flag value is zero. The flag value is the inserted bits for op code 2 and the old field for every other op code.
- R11: `start` is accepted only while `busy` is low, and a `start` raised while busy has no effect. `done` is high for exactly one cycle. `result` and the flags hold until the next operation computes new values. After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse, sampled while idle |
| op | input | 3 | Operation code (see R5 to R9) |
| base_addr | input | ADDR_W | Base byte address |
| bit_ofs | input | OFS_W | Signed bit offset from the base |
| len_code | input | LEN_W | Field length code, 0 means FIELD_W |
| ins_val | input | FIELD_W | Value for insertion |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | FIELD_W | Operation result |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | ADDR_W | Byte address of the access |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid the cycle after a read request |

## Verification
The case that needs care is a new `start` arriving in the same cycle as a write-back beat or the completion pulse of the current operation. The bench provokes it by holding `start` high, with different arguments, for the whole of a running insert. It then requires that every bus beat still matches the reference queue and that the final memory image matches. The result must be that of the original request, and no extra operation may follow it.

// File: rtl/bfu_pkg.sv
package bfu_pkg;

   typedef enum logic [2:0] {
      BF_EXTU = 3'd0,
      BF_EXTS = 3'd1,
      BF_INS  = 3'd2,
      BF_CHG  = 3'd3,
      BF_CLR  = 3'd4,
      BF_SET  = 3'd5,
      BF_FFO  = 3'd6,
      BF_RSV  = 3'd7
   } bf_op_e;

   typedef enum logic [2:0] {
      S_IDLE   = 3'd0,
      S_RD_REQ = 3'd1,
      S_RD_CAP = 3'd2,
      S_CALC   = 3'd3,
      S_WR     = 3'd4,
      S_DONE   = 3'd5
   } bf_state_e;

   function automatic logic op_writes(input bf_op_e o);
      return (o == BF_INS) || (o == BF_CHG) || (o == BF_CLR) || (o == BF_SET);
   endfunction

endpackage

// File: rtl/bfu_geom.sv
module bfu_geom #(
   parameter int ADDR_W  = 32,
   parameter int OFS_W   = 32,
   parameter int FIELD_W = 32,
   localparam int LEN_W  = $clog2(FIELD_W),
   localparam int LW     = LEN_W + 1,
   localparam int WIN_BYTES = FIELD_W / 8 + 1,
   localparam int IDX_W  = $clog2(WIN_BYTES)
) (
   input  logic [ADDR_W-1:0] base_addr,
   input  logic [OFS_W-1:0]  bit_ofs,
   input  logic [LEN_W-1:0]  len_code,
   output logic [ADDR_W-1:0] eff_addr,
   output logic [2:0]        bit_pos,
   output logic [LW-1:0]     fld_len,
   output logic [IDX_W-1:0]  last_idx
);

   logic signed [OFS_W-1:0] byte_delta;
   logic [LW:0]             span;

   // R1: zero code selects the full width
   assign fld_len = (len_code == '0) ? LW'(FIELD_W) : {1'b0, len_code};

   // R2: arithmetic shift keeps negative offsets below the base
   assign byte_delta = $signed(bit_ofs) >>> 3;
   assign eff_addr   = base_addr + ADDR_W'(byte_delta);
   assign bit_pos    = bit_ofs[2:0];

   // R3: last byte index of the span
   assign span     = (LW+1)'(bit_pos) + (LW+1)'(fld_len) - (LW+1)'(1);
   assign last_idx = IDX_W'(span >> 3);

   always_comb begin
      p_len_range_r1: assert (fld_len >= LW'(1) && fld_len <= LW'(FIELD_W))
         else $error("field length out of range");
      p_span_limit_r3: assert (int'(last_idx) < WIN_BYTES)
         else $error("span exceeds window");
   end

endmodule

// File: rtl/bfu_field_alu.sv
module bfu_field_alu import bfu_pkg::*; #(
   parameter int OFS_W   = 32,
   parameter int FIELD_W = 32,
   localparam int LEN_W  = $clog2(FIELD_W),
   localparam int LW     = LEN_W + 1,
   localparam int WIN_W  = 8 * (FIELD_W / 8 + 1)
) (
   input  bf_op_e             op,
   input  logic [WIN_W-1:0]   win,
   input  logic [2:0]         bit_pos,
   input  logic [LW-1:0]      fld_len,
   input  logic [OFS_W-1:0]   bit_ofs,
   input  logic [FIELD_W-1:0] ins_val,
   output logic [WIN_W-1:0]   new_win,
   output logic [FIELD_W-1:0] res,
   output logic               neg,
   output logic               zero
);

   logic [LW-1:0]      sh_amt;
   logic [FIELD_W-1:0] top_mask, len_mask, fld_raw, fld_top;
   logic [FIELD_W-1:0] old_u, old_s, ins_top, flag_v;
   logic [WIN_W-1:0]   win_mask, ins_win;
   logic [LW-1:0]      lead;
   logic               found;
   logic [OFS_W-1:0]   ffo_sum;

   assign sh_amt   = LW'(FIELD_W) - fld_len;
   assign top_mask = {FIELD_W{1'b1}} << sh_amt;
   assign len_mask = {FIELD_W{1'b1}} >> sh_amt;

   // R4: field left-justified, first byte's MSB is field bit 0
   assign fld_raw = FIELD_W'(win >> (4'd8 - {1'b0, bit_pos}));
   assign fld_top = fld_raw & top_mask;

   // R5: extraction
   assign old_u = fld_top >> sh_amt;
   assign old_s = FIELD_W'($signed(fld_top) >>> sh_amt);

   // R6: insertion aligned into the window
   assign ins_top  = ins_val << sh_amt;
   assign win_mask = {top_mask, 8'h00} >> bit_pos;
   assign ins_win  = {ins_top, 8'h00} >> bit_pos;

   // R9: leading-zero count inside the field
   always_comb begin
      lead  = fld_len;
      found = 1'b0;
      for (int i = FIELD_W - 1; i >= 0; i--) begin
         if (!found && fld_top[i]) begin
            lead  = LW'(FIELD_W - 1 - i);
            found = 1'b1;
         end
      end
   end
   assign ffo_sum = bit_ofs + OFS_W'(lead);

   always_comb begin
      case (op)
         BF_EXTS: res = old_s;
         BF_INS:  res = ins_val & len_mask;
         BF_FFO:  res = FIELD_W'($signed(ffo_sum));
         default: res = old_u;
      endcase
   end

   // R10
   assign flag_v = (op == BF_INS) ? ins_top : fld_top;
   assign neg    = flag_v[FIELD_W-1];
   assign zero   = (flag_v == '0);

   // R7 / R6
   always_comb begin
      case (op)
         BF_INS:  new_win = (win & ~win_mask) | ins_win;
         BF_CHG:  new_win = win ^ win_mask;
         BF_CLR:  new_win = win & ~win_mask;
         BF_SET:  new_win = win | win_mask;
         default: new_win = win;
      endcase
   end

   always_comb begin
      p_outside_kept_r8: assert (((new_win ^ win) & ~win_mask) == '0)
         else $error("bits outside the field altered");
   end

endmodule

// File: rtl/bfu_seq.sv
module bfu_seq import bfu_pkg::*; #(
   parameter int ADDR_W  = 32,
   parameter int OFS_W   = 32,
   parameter int FIELD_W = 32,
   localparam int LEN_W  = $clog2(FIELD_W),
   localparam int LW     = LEN_W + 1,
   localparam int WIN_BYTES = FIELD_W / 8 + 1,
   localparam int WIN_W  = 8 * WIN_BYTES,
   localparam int IDX_W  = $clog2(WIN_BYTES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  bf_op_e             op_in,
   input  logic [ADDR_W-1:0]  eff_addr_in,
   input  logic [2:0]         bit_pos_in,
   input  logic [LW-1:0]      fld_len_in,
   input  logic [IDX_W-1:0]   last_idx_in,
   input  logic [OFS_W-1:0]   bit_ofs_in,
   input  logic [FIELD_W-1:0] ins_val_in,
   input  logic [7:0]         mem_rdata,
   input  logic [WIN_W-1:0]   new_win,
   output logic               busy,
   output logic               done,
   output logic               calc_en,
   output logic               mem_req,
   output logic               mem_we,
   output logic [ADDR_W-1:0]  mem_addr,
   output logic [7:0]         mem_wdata,
   output bf_op_e             op_q,
   output logic [2:0]         bit_pos_q,
   output logic [LW-1:0]      fld_len_q,
   output logic [OFS_W-1:0]   bit_ofs_q,
   output logic [FIELD_W-1:0] ins_val_q,
   output logic [WIN_W-1:0]   win_q
);

   bf_state_e          state;
   logic [IDX_W-1:0]   idx, last_q;
   logic [ADDR_W-1:0]  a0_q;
   logic               accept;
   logic [7:0]         nw_b [WIN_BYTES];

   assign accept = (state == S_IDLE) && start;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= S_IDLE;
         idx       <= '0;
         last_q    <= '0;
         a0_q      <= '0;
         op_q      <= BF_EXTU;
         bit_pos_q <= '0;
         fld_len_q <= '0;
         bit_ofs_q <= '0;
         ins_val_q <= '0;
      end else begin
         case (state)
            S_IDLE: if (start) begin
               a0_q      <= eff_addr_in;
               last_q    <= last_idx_in;
               op_q      <= op_in;
               bit_pos_q <= bit_pos_in;
               fld_len_q <= fld_len_in;
               bit_ofs_q <= bit_ofs_in;
               ins_val_q <= ins_val_in;
               idx       <= '0;
               state     <= S_RD_REQ;
            end
            S_RD_REQ: state <= S_RD_CAP;
            S_RD_CAP: begin
               if (idx == last_q) begin
                  idx   <= '0;
                  state <= S_CALC;
               end else begin
                  idx   <= idx + IDX_W'(1);
                  state <= S_RD_REQ;
               end
            end
            S_CALC: begin
               idx   <= '0;
               state <= op_writes(op_q) ? S_WR : S_DONE;
            end
            S_WR: begin
               if (idx == last_q) state <= S_DONE;
               else idx <= idx + IDX_W'(1);
            end
            default: state <= S_IDLE;
         endcase
      end
   end

   // window byte lanes, byte 0 at the top (R4)
   for (genvar b = 0; b < WIN_BYTES; b++) begin : g_lane
      logic [7:0] lane_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            lane_q <= '0;
         else if (accept)
            lane_q <= '0;
         else if (state == S_RD_CAP && idx == IDX_W'(b))
            lane_q <= mem_rdata;
      end
      assign win_q[WIN_W-1-8*b -: 8] = lane_q;
      assign nw_b[b] = new_win[WIN_W-1-8*b -: 8];
   end

   assign busy      = (state != S_IDLE);
   assign done      = (state == S_DONE);
   assign calc_en   = (state == S_CALC);
   assign mem_req   = (state == S_RD_REQ) || (state == S_WR);
   assign mem_we    = (state == S_WR);
   assign mem_addr  = a0_q + ADDR_W'(idx);
   assign mem_wdata = nw_b[idx];

   p_done_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_start_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> ($stable(a0_q) && $stable(op_q) && $stable(ins_val_q)));

   p_ro_no_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> op_writes(op_q));

   p_no_read_after_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |=> !(mem_req && !mem_we));

   p_wr_ascending_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we && $past(mem_req && mem_we)) |-> (mem_addr == $past(mem_addr) + ADDR_W'(1)));

   p_beat_in_span_r3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (idx <= last_q));

endmodule

// File: rtl/bfu_mem_bitfield.sv
module bfu_mem_bitfield import bfu_pkg::*; #(
   parameter int ADDR_W  = 32,
   parameter int OFS_W   = 32,
   parameter int FIELD_W = 32,
   localparam int LEN_W  = $clog2(FIELD_W),
   localparam int LW     = LEN_W + 1,
   localparam int WIN_BYTES = FIELD_W / 8 + 1,
   localparam int WIN_W  = 8 * WIN_BYTES,
   localparam int IDX_W  = $clog2(WIN_BYTES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [2:0]         op,
   input  logic [ADDR_W-1:0]  base_addr,
   input  logic [OFS_W-1:0]   bit_ofs,
   input  logic [LEN_W-1:0]   len_code,
   input  logic [FIELD_W-1:0] ins_val,
   output logic               busy,
   output logic               done,
   output logic [FIELD_W-1:0] result,
   output logic               flag_n,
   output logic               flag_z,
   output logic               mem_req,
   output logic               mem_we,
   output logic [ADDR_W-1:0]  mem_addr,
   output logic [7:0]         mem_wdata,
   input  logic [7:0]         mem_rdata
);

   if (FIELD_W < 8 || (FIELD_W & (FIELD_W - 1)) != 0) begin : g_bad_field
      $error("FIELD_W must be a power of two of at least 8");
   end
   if (OFS_W < 4 || ADDR_W < 2) begin : g_bad_width
      $error("OFS_W or ADDR_W too narrow");
   end

   logic [ADDR_W-1:0]  g_addr;
   logic [2:0]         g_pos;
   logic [LW-1:0]      g_len;
   logic [IDX_W-1:0]   g_last;
   logic               calc_en;
   bf_op_e             op_q;
   logic [2:0]         pos_q;
   logic [LW-1:0]      len_q;
   logic [OFS_W-1:0]   ofs_q;
   logic [FIELD_W-1:0] val_q, alu_res;
   logic [WIN_W-1:0]   win_q, new_win;
   logic               alu_n, alu_z;

   bfu_geom #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .FIELD_W(FIELD_W)) u_geom (
      .base_addr (base_addr),
      .bit_ofs   (bit_ofs),
      .len_code  (len_code),
      .eff_addr  (g_addr),
      .bit_pos   (g_pos),
      .fld_len   (g_len),
      .last_idx  (g_last)
   );

   bfu_seq #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .FIELD_W(FIELD_W)) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .op_in       (bf_op_e'(op)),
      .eff_addr_in (g_addr),
      .bit_pos_in  (g_pos),
      .fld_len_in  (g_len),
      .last_idx_in (g_last),
      .bit_ofs_in  (bit_ofs),
      .ins_val_in  (ins_val),
      .mem_rdata   (mem_rdata),
      .new_win     (new_win),
      .busy        (busy),
      .done        (done),
      .calc_en     (calc_en),
      .mem_req     (mem_req),
      .mem_we      (mem_we),
      .mem_addr    (mem_addr),
      .mem_wdata   (mem_wdata),
      .op_q        (op_q),
      .bit_pos_q   (pos_q),
      .fld_len_q   (len_q),
      .bit_ofs_q   (ofs_q),
      .ins_val_q   (val_q),
      .win_q       (win_q)
   );

   bfu_field_alu #(.OFS_W(OFS_W), .FIELD_W(FIELD_W)) u_alu (
      .op      (op_q),
      .win     (win_q),
      .bit_pos (pos_q),
      .fld_len (len_q),
      .bit_ofs (ofs_q),
      .ins_val (val_q),
      .new_win (new_win),
      .res     (alu_res),
      .neg     (alu_n),
      .zero    (alu_z)
   );

   // R11: results held between computations
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         result <= '0;
         flag_n <= 1'b0;
         flag_z <= 1'b0;
      end else if (calc_en) begin
         result <= alu_res;
         flag_n <= alu_n;
         flag_z <= alu_z;
      end
   end

   p_hold_result_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !calc_en |=> $stable(result) && $stable(flag_n) && $stable(flag_z));

endmodule

// File: tb/tb_bfu_mem_bitfield.sv
module tb_bfu_mem_bitfield;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [2:0]  op = 3'd0;
   logic [31:0] base_addr = 32'd0;
   logic [31:0] bit_ofs = 32'd0;
   logic [4:0]  len_code = 5'd0;
   logic [31:0] ins_val = 32'd0;
   logic        busy, done, flag_n, flag_z, mem_req, mem_we;
   logic [31:0] result, mem_addr;
   logic [7:0]  mem_wdata;
   logic [7:0]  rd_q;

   int checks = 0;
   int fails  = 0;

   logic [7:0]  mem     [256];
   logic [7:0]  exp_mem [256];
   int unsigned q_addr [$];
   bit          q_we   [$];
   logic [7:0]  q_data [$];

   always #5 clk = ~clk;

   bfu_mem_bitfield dut (
      .clk(clk), .rst_n(rst_n), .start(start), .op(op), .base_addr(base_addr),
      .bit_ofs(bit_ofs), .len_code(len_code), .ins_val(ins_val), .busy(busy),
      .done(done), .result(result), .flag_n(flag_n), .flag_z(flag_z),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(rd_q)
   );

   // byte memory model, read data one cycle after request
   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 256; i++) mem[i] <= 8'((i * 37 + 11) ^ (i >> 2));
         rd_q <= 8'h00;
      end else if (mem_req) begin
         if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
         else        rd_q <= mem[mem_addr[7:0]];
      end
   end

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // per-cycle bus comparison against the reference beat queue
   always @(negedge clk) begin
      if (rst_n && mem_req) begin
         if (q_addr.size() == 0) begin
            chk("R3", "unexpected beat", mem_addr, 32'hFFFF_FFFF);
         end else begin
            int unsigned ea;
            bit          ew;
            logic [7:0]  ed;
            ea = q_addr.pop_front();
            ew = q_we.pop_front();
            ed = q_data.pop_front();
            chk("R2", "beat address", mem_addr, ea);
            chk("R8", "beat direction", {31'd0, mem_we}, {31'd0, ew});
            if (ew) chk("R8", "write data", {24'd0, mem_wdata}, {24'd0, ed});
         end
      end
   end

   function automatic logic gbit(input longint ba);
      return exp_mem[int'((ba >>> 3) & 255)][7 - int'(ba & 7)];
   endfunction

   task automatic sbit(input longint ba, input logic v);
      exp_mem[int'((ba >>> 3) & 255)][7 - int'(ba & 7)] = v;
   endtask

   task automatic ref_op(input int opc, input int unsigned addr, input int ofs, input int lc,
                         input logic [31:0] val, output logic [31:0] r, output logic n, output logic z);
      int          L;
      longint      ba;
      logic [31:0] f, fv, lm;
      int          nb, k1;
      int unsigned sb;
      bit          wr;
      for (int i = 0; i < 256; i++) exp_mem[i] = mem[i];
      L  = (lc == 0) ? 32 : lc;                              // R1
      ba = longint'(addr) * 8 + longint'(ofs);
      f  = 32'd0;
      for (int k = 0; k < L; k++) f = {f[30:0], gbit(ba + k)}; // R4
      nb = ((ofs & 7) + L - 1) / 8 + 1;                      // R3
      sb = addr + int'(ofs >>> 3);                           // R2
      lm = (L == 32) ? 32'hFFFF_FFFF : ((32'd1 << L) - 32'd1);
      for (int i = 0; i < nb; i++) begin
         q_addr.push_back(sb + i); q_we.push_back(1'b0); q_data.push_back(8'h00);
      end
      wr = 1'b0;
      fv = f;
      case (opc)
         1: r = f[L-1] ? (f | ~lm) : f;
         2: begin
            r = val & lm; fv = r; wr = 1'b1;
            for (int k = 0; k < L; k++) sbit(ba + k, r[L-1-k]);
         end
         3: begin r = f; wr = 1'b1; for (int k = 0; k < L; k++) sbit(ba + k, ~gbit(ba + k)); end
         4: begin r = f; wr = 1'b1; for (int k = 0; k < L; k++) sbit(ba + k, 1'b0); end
         5: begin r = f; wr = 1'b1; for (int k = 0; k < L; k++) sbit(ba + k, 1'b1); end
         6: begin
            k1 = L;
            for (int k = L - 1; k >= 0; k--) if (gbit(ba + k)) k1 = k;
            r = 32'(ofs + k1);
         end
         default: r = f;
      endcase
      n = fv[L-1];
      z = (fv == 32'd0);
      if (wr)
         for (int i = 0; i < nb; i++) begin
            q_addr.push_back(sb + i); q_we.push_back(1'b1);
            q_data.push_back(exp_mem[(sb + i) & 255]);
         end
   endtask

   task automatic run_op(input string req, input int opc, input int unsigned addr, input int ofs,
                         input int lc, input logic [31:0] val, input bit noise);
      logic [31:0] er;
      logic        en, ez;
      int          cyc;
      ref_op(opc, addr, ofs, lc, val, er, en, ez);
      start = 1'b1; op = 3'(opc); base_addr = addr; bit_ofs = ofs;
      len_code = 5'(lc); ins_val = val;
      @(negedge clk);
      if (noise) begin
         // R11: a second request during the whole operation must be ignored
         op = 3'd5; base_addr = addr + 7; bit_ofs = 32'd3; len_code = 5'd4; ins_val = ~val;
      end else start = 1'b0;
      cyc = 0;
      while (!done && cyc < 200) begin
         @(negedge clk);
         cyc++;
      end
      start = 1'b0;
      if (!done) begin
         fails++; checks++;
         $display("FAIL R11 watchdog: actual busy expected done");
      end
      chk(req, "result", result, er);
      chk("R10", "flag_n", {31'd0, flag_n}, {31'd0, en});
      chk("R10", "flag_z", {31'd0, flag_z}, {31'd0, ez});
      @(negedge clk);
      chk("R11", "done one cycle", {31'd0, done}, 32'd0);
      chk("R11", "idle after done", {31'd0, busy}, 32'd0);
      chk("R3", "beats left", 32'(q_addr.size()), 32'd0);
      q_addr.delete(); q_we.delete(); q_data.delete();
      begin
         int bad;
         bad = 0;
         for (int i = 0; i < 256; i++) if (mem[i] !== exp_mem[i]) bad++;
         chk("R8", "memory image", 32'(bad), 32'd0);
      end
   endtask

   always @(posedge clk) begin
      static int total = 0;
      total++;
      if (total > 150000) begin
         fails++;
         $display("FAIL global watchdog: actual %0d cycles expected fewer", total);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      int unsigned s;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R11", "reset busy", {31'd0, busy}, 32'd0);
      chk("R11", "reset done", {31'd0, done}, 32'd0);
      chk("R11", "reset result", result, 32'd0);
      chk("R11", "reset flags", {30'd0, flag_n, flag_z}, 32'd0);
      chk("R11", "reset bus", {31'd0, mem_req}, 32'd0);

      run_op("R4", 0, 100, 0, 8, 0, 0);
      run_op("R1", 0, 100, 5, 0, 0, 0);
      run_op("R5", 1, 100, -13, 7, 0, 0);
      run_op("R5", 1, 140, 3, 12, 0, 0);
      run_op("R6", 2, 120, 6, 20, 32'hABCD_E123, 0);
      run_op("R7", 3, 120, -1, 0, 0, 0);
      run_op("R7", 4, 110, 9, 1, 0, 0);
      run_op("R7", 5, 130, 0, 0, 0, 0);
      run_op("R7", 4, 150, 4, 10, 0, 0);
      run_op("R9", 6, 150, 4, 10, 0, 0);
      run_op("R10", 0, 150, 4, 10, 0, 0);
      run_op("R9", 6, 130, -20, 16, 0, 0);
      run_op("R5", 7, 100, 11, 17, 0, 0);
      run_op("R11", 2, 160, -9, 25, 32'h0123_4567, 1);
      s = 32'h1234_5678;
      for (int t = 0; t < 80; t++) begin
         s = s * 1103515245 + 12345;
         run_op("R8", int'((s >> 16) % 8), 96 + ((s >> 20) % 32), int'((s >> 8) % 81) - 40,
                int'(s % 32), s ^ (s << 7), 0);
      end
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule